// File: doc/BRIEF.md
# Serial Clock Line Stuck-Level Timeout Detector

This block measures how long the clock line of a two-wire serial bus has been held at a single level and raises a sticky timeout flag once that time exceeds the range of an internal counter. The line level arrives already synchronized. A reference tick sets the counting rate. At run time the counter can be either a full 16-bit counter (long mode) or a 14-bit counter (short mode). Counting can be allowed separately for time spent low and time spent high.

Any change of level restarts the measurement, so only unbroken time at one level counts. Software can load the counter directly through a preset port, for example to shorten the next timeout. Software clears the flag once it has handled the event. When the global enable is off, the counter is held at zero.

Top module: `scl_timeout_monitor`

## Requirements
- R1: After reset, `count_o` is 0 and `timeout_o` is 0. The previous-level register is taken as high after reset.
- R2: While `enable_i` is 0, `count_o` is 0 from the next cycle on and no timeout is raised.
- R3: While enabled, with no preset and no level change, `count_o` rises by exactly one in each cycle with `tick_i`=1 and the current level enabled for counting. It holds in cycles without a tick.
- R4: `count_low_en_i` permits counting while `scl_i`=0 and `count_high_en_i` permits counting while `scl_i`=1. A level whose enable is 0 leaves `count_o` unchanged.
- R5: If `scl_i` differs from its value in the previous cycle, the counter goes to 0 in that cycle. This applies while enabled and no preset is written.
- R6: In long mode (`short_mode_i`=0), a counted tick at `count_o`=16'hFFFF wraps the counter to 0 and sets `timeout_o`.
- R7: In short mode (`short_mode_i`=1), only bits 13:0 take part. Bits 15:14 of `count_o` read 0. A counted tick at 14'h3FFF wraps the counter to 0 and sets `timeout_o`.
- R8: While enabled, `preset_we_i`=1 loads `preset_val_i` into the counter. In short mode, bits 15:14 are dropped. The preset takes priority over level changes and counting.
- R9: `timeout_o` stays set until a cycle with `flag_clr_i`=1. If a clear and a wrap happen in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronized clock-line level |
| tick_i | input | 1 | Reference count tick, one cycle wide |
| enable_i | input | 1 | Global timeout-detection enable |
| short_mode_i | input | 1 | 0 selects 16-bit counting, 1 selects 14-bit counting |
| count_low_en_i | input | 1 | Allow counting while the line is low |
| count_high_en_i | input | 1 | Allow counting while the line is high |
| preset_we_i | input | 1 | Load the counter from `preset_val_i` |
| preset_val_i | input | 16 | Counter preset value |
| flag_clr_i | input | 1 | Clear the timeout flag |
| count_o | output | 16 | Current counter value |
| timeout_o | output | 1 | Sticky timeout flag |

## Verification
The counter and the flag are both single registers, so every input cycle has its effect on `count_o` and `timeout_o` exactly one clock edge later. The bench drives inputs on the falling edge. After the next rising edge it advances its own model by one cycle, then compares both outputs on the following falling edge, so each comparison sees the result of precisely one set of inputs. Directed sequences drive the counter through the long and short wraps, run a preset to just below the wrap, and land a clear on the same edge as a wrap. Random stimulus with rare level changes and near-maximum presets covers the remaining combinations.

// File: rtl/scl_timeout_monitor.sv
module scl_timeout_monitor #(
  parameter int LONG_W  = 16,
  parameter int SHORT_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              tick_i,
  input  logic              enable_i,
  input  logic              short_mode_i,
  input  logic              count_low_en_i,
  input  logic              count_high_en_i,
  input  logic              preset_we_i,
  input  logic [LONG_W-1:0] preset_val_i,
  input  logic              flag_clr_i,
  output logic [LONG_W-1:0] count_o,
  output logic              timeout_o
);
  localparam logic [LONG_W-1:0] LONG_MAX  = '1;
  localparam logic [LONG_W-1:0] SHORT_MAX = {{(LONG_W-SHORT_W){1'b0}}, {SHORT_W{1'b1}}};

  logic              scl_q;
  logic [LONG_W-1:0] cnt, cnt_nxt, limit, cnt_m;
  logic              scl_chg, level_ok, advance, wrap;

  assign limit    = short_mode_i ? SHORT_MAX : LONG_MAX;
  assign cnt_m    = cnt & limit;
  assign scl_chg  = scl_i ^ scl_q;
  assign level_ok = scl_i ? count_high_en_i : count_low_en_i;
  assign advance  = enable_i && !preset_we_i && !scl_chg && tick_i && level_ok;
  assign wrap     = advance && (cnt_m == limit);

  always_comb begin
    if (!enable_i)        cnt_nxt = '0;
    else if (preset_we_i) cnt_nxt = preset_val_i & limit;
    else if (scl_chg)     cnt_nxt = '0;
    else if (wrap)        cnt_nxt = '0;
    else if (advance)     cnt_nxt = cnt_m + 1'b1;
    else                  cnt_nxt = cnt_m;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q     <= 1'b1;
      cnt       <= '0;
      timeout_o <= 1'b0;
    end else begin
      scl_q <= scl_i;
      cnt   <= cnt_nxt;
      if (wrap)            timeout_o <= 1'b1;
      else if (flag_clr_i) timeout_o <= 1'b0;
    end
  end

  assign count_o = cnt;
endmodule

module scl_timeout_monitor_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         scl_i,
  input logic         scl_q,
  input logic         tick_i,
  input logic         enable_i,
  input logic         short_mode_i,
  input logic         preset_we_i,
  input logic         flag_clr_i,
  input logic [W-1:0] count_o,
  input logic         timeout_o
);
  a_r2_disabled_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> count_o == '0);

  a_r4_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    enable_i && !preset_we_i && !short_mode_i && scl_i == scl_q && !tick_i
    |=> count_o == $past(count_o));

  a_r5_edge_clear: assert property (@(posedge clk) disable iff (!rst_n)
    enable_i && !preset_we_i && scl_i != scl_q |=> count_o == '0);

  a_r7_short_upper: assert property (@(posedge clk) disable iff (!rst_n)
    short_mode_i |=> count_o[W-1:W-2] == 2'b00);

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o && !flag_clr_i |=> timeout_o);

  a_r9_set_needs_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !timeout_o && !(enable_i && tick_i && !preset_we_i) |=> !timeout_o);
endmodule

bind scl_timeout_monitor scl_timeout_monitor_chk #(.W(LONG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .scl_q(scl_q), .tick_i(tick_i),
  .enable_i(enable_i), .short_mode_i(short_mode_i), .preset_we_i(preset_we_i),
  .flag_clr_i(flag_clr_i), .count_o(count_o), .timeout_o(timeout_o)
);

// File: tb/test_scl_timeout_monitor.sv
module test_scl_timeout_monitor;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, tick = 1'b0, en = 1'b0, sm = 1'b0, len = 1'b0, hen = 1'b0;
  logic we = 1'b0, clr = 1'b0;
  logic [15:0] pv = '0;
  logic [15:0] count;
  logic        tout;

  int checks = 0, fails = 0;
  logic [15:0] m_cnt = '0;
  logic        m_flag = 1'b0, m_prev = 1'b1;
  string       tag = "R3";

  always #(PERIOD/2) clk = ~clk;

  scl_timeout_monitor i_scl_timeout_monitor (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .tick_i(tick), .enable_i(en),
    .short_mode_i(sm), .count_low_en_i(len), .count_high_en_i(hen),
    .preset_we_i(we), .preset_val_i(pv), .flag_clr_i(clr),
    .count_o(count), .timeout_o(tout)
  );

  function automatic logic [16:0] model_next(logic [15:0] c);
    logic [15:0] mask, cm;
    mask = sm ? 16'h3FFF : 16'hFFFF;
    cm   = c & mask;
    if (!en)                            return {1'b0, 16'h0};
    if (we)                             return {1'b0, pv & mask};
    if (scl != m_prev)                  return {1'b0, 16'h0};
    if (tick && (scl ? hen : len)) begin
      if (cm == mask)                   return {1'b1, 16'h0};
      return {1'b0, cm + 16'd1};
    end
    return {1'b0, cm};
  endfunction

  task automatic check(string t, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  task automatic cyc();
    logic [16:0] n;
    @(posedge clk);
    n      = model_next(m_cnt);
    m_flag = n[16] ? 1'b1 : (clr ? 1'b0 : m_flag);
    m_cnt  = n[15:0];
    m_prev = scl;
    @(negedge clk);
    check(tag, count, m_cnt);
    check(tag, {15'b0, tout}, {15'b0, m_flag});
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    tag = "R1";
    check("R1 count", count, 16'h0);
    check("R1 flag", {15'b0, tout}, 16'h0);
    rst_n = 1'b1;

    tag = "R2"; tick = 1; len = 1; hen = 1;
    repeat (5) cyc();
    check("R2 disabled", count, 16'h0);

    tag = "R3"; en = 1;
    repeat (10) cyc();
    check("R3 ten ticks", count, 16'd10);
    tick = 0; repeat (3) cyc();
    check("R3 no tick hold", count, 16'd10);

    tag = "R4"; tick = 1; hen = 0;
    repeat (4) cyc();
    check("R4 high disabled", count, 16'd10);

    tag = "R5"; scl = 0; cyc();
    check("R5 edge clear", count, 16'd0);
    tag = "R4"; repeat (3) cyc();
    check("R4 low counts", count, 16'd3);

    tag = "R8"; we = 1; pv = 16'hFFF0; cyc(); we = 0;
    check("R8 preset", count, 16'hFFF0);
    tag = "R6"; repeat (16) cyc();
    check("R6 long wrap count", count, 16'h0);
    check("R6 long wrap flag", {15'b0, tout}, 16'h1);

    tag = "R9"; repeat (3) cyc();
    check("R9 sticky", {15'b0, tout}, 16'h1);
    clr = 1; cyc(); clr = 0;
    check("R9 cleared", {15'b0, tout}, 16'h0);
    we = 1; pv = 16'hFFFF; cyc(); we = 0;
    clr = 1; cyc(); clr = 0;
    check("R9 clear vs wrap", {15'b0, tout}, 16'h1);
    clr = 1; cyc(); clr = 0;

    tag = "R7"; sm = 1; we = 1; pv = 16'hFFFF; cyc(); we = 0;
    check("R7 preset masked", count, 16'h3FFF);
    cyc();
    check("R7 short wrap", {15'b0, tout}, 16'h1);
    clr = 1; cyc(); clr = 0;
    scl = 1; hen = 1; cyc();
    repeat (16383) cyc();
    check("R7 before wrap", count, 16'h3FFF);
    check("R7 no flag yet", {15'b0, tout}, 16'h0);
    cyc();
    check("R7 full short run", {15'b0, tout}, 16'h1);

    tag = "R3";
    void'($urandom(32'h5EED));
    for (int i = 0; i < 4000; i++) begin
      en   = ($urandom % 16) != 0;
      tick = $urandom % 2;
      sm   = ($urandom % 64) == 0 ? ~sm : sm;
      len  = ($urandom % 8) != 0;
      hen  = ($urandom % 8) != 0;
      scl  = ($urandom % 40) == 0 ? ~scl : scl;
      we   = ($urandom % 50) == 0;
      pv   = 16'hFFFF - 16'($urandom % 8);
      clr  = ($urandom % 30) == 0;
      cyc();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule